// File: doc/BRIEF.md
# DMA Channel Transfer Engine

This block runs the transfer of a single DMA channel. Software or a control-table fetcher places a packed 32-bit control word and two end pointers on its inputs, one for the source and one for the destination, and then pulses `start`. The engine copies items one at a time: it reads an item from the source and writes it to the destination in the next cycle. The item address is measured backwards from the end pointer, so the last item of the transfer always lands exactly on the end pointer. Either side can be held at a fixed address so that it can reach a FIFO register.

The engine competes for the memory bus through a request/grant pair. Once it wins the bus, it keeps it for a burst of 2^n items, where n is the arbitration exponent in the control word. It then gives the bus up for one cycle and writes an updated control word back. In auto-request mode, one start runs the whole transfer. In basic mode, the transfer continues past a burst boundary only while the channel request is held; otherwise the channel parks. Software can resume a parked channel later by feeding the written-back word in again as the new control word.

At completion, the engine pulses `done` together with a final write-back in which the mode field is cleared to stop.

Top module: `dma_chan_engine`

## Requirements
- R1: A start with control-word bits 2:0 equal to 2 (auto-request) moves (bits 13:4)+1 items, each read from the source and written to the destination in the following cycle, with no further request needed.
- R2: While r items remain, including the current one, the item address is end pointer − (r−1)·4 on an incrementing side, and exactly the end pointer on a side marked fixed.
- R3: With bits 17:14 equal to n, `bus_req` drops for exactly one cycle after every 2^n items, unless the transfer has finished.
- R4: No memory access starts until `bus_gnt` has been seen high while `bus_req` is high. Until then, `bus_req` stays high.
- R5: At each burst boundary, `wb_valid` pulses for one cycle. `wb_word` equals the loaded control word with bits 13:4 replaced by the remaining item count minus one.
- R6: In basic mode (bits 2:0 equal to 1), the engine goes idle after a boundary write-back when `chan_req` is low, and no `done` pulse is produced. It continues when `chan_req` is high.
- R7: At completion, `done` and `wb_valid` pulse together for one cycle. `wb_word` then has bits 2:0 and bits 13:4 cleared, and every other bit unchanged.
- R8: A start whose mode field is neither 1 nor 2 is ignored. It produces no bus request, no memory access and no `done`.
- R9: A start that arrives during a transfer is ignored.
- R10: During and right after reset, `bus_req`, `mem_req`, `wb_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer from the presented control word |
| chan_req | input | 1 | Channel request level, used at basic-mode boundaries |
| ctl_word | input | 32 | Packed control word |
| src_end | input | AW | Source end pointer |
| dst_end | input | AW | Destination end pointer |
| src_fixed | input | 1 | Source address does not step |
| dst_fixed | input | 1 | Destination address does not step |
| bus_req | output | 1 | Bus request, held for the whole burst |
| bus_gnt | input | 1 | Bus grant |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid the cycle after a read |
| wb_valid | output | 1 | Control-word write-back strobe |
| wb_word | output | 32 | Updated control word |
| done | output | 1 | Transfer complete pulse |

## Verification
On every cycle, the bound assertions check that each read is followed at once by a write, and that a burst starts only after a grant. They also check that the bus is released while a write-back is being presented, that `done` always comes with a stop-mode write-back, and that both strobes last a single cycle. Only the bench scenarios can show that the right items arrive at the right destination addresses, and that bursts break at the programmed length. The same applies to a parked basic-mode channel resuming correctly from its written-back word, and to ignored starts leaving the bus untouched.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;
  localparam int CTL_W    = 32;
  localparam int MODE_LSB = 0;
  localparam int MODE_W   = 3;
  localparam int NUB_BIT  = 3;
  localparam int SIZE_LSB = 4;
  localparam int SIZE_W   = 10;
  localparam int ARB_LSB  = 14;
  localparam int ARB_W    = 4;

  localparam logic [MODE_W-1:0] MODE_STOP  = 3'd0;
  localparam logic [MODE_W-1:0] MODE_BASIC = 3'd1;
  localparam logic [MODE_W-1:0] MODE_AUTO  = 3'd2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ARB, ST_RD, ST_WR, ST_BND, ST_FIN
  } eng_state_t;
endpackage

// File: rtl/dma_item_ctr.sv
module dma_item_ctr #(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic [CW-1:0] count
);
  logic [CW-1:0] count_d;

  always_comb begin
    count_d = count;
    if (load)     count_d = load_val;
    else if (dec) count_d = count - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          count <= '0;
    else if (load | dec) count <= count_d;
  end
endmodule

// File: rtl/dma_burst_ctr.sv
module dma_burst_ctr #(
  parameter int EW = 4,
  localparam int BW = 2 ** EW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  input  logic [EW-1:0] exp_n,
  output logic          last
);
  logic [BW-1:0] cnt, cnt_d;
  logic [BW:0]   limit;

  assign limit = (BW+1)'(1) << exp_n;
  assign last  = ({1'b0, cnt} + (BW+1)'(1)) == limit;

  always_comb begin
    cnt_d = cnt;
    if (clr)       cnt_d = '0;
    else if (step) cnt_d = cnt + BW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr | step) cnt <= cnt_d;
  end
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
  parameter int AW    = 32,
  parameter int CW    = 11,
  parameter int SHIFT = 2
) (
  input  logic [AW-1:0] end_ptr,
  input  logic [CW-1:0] remaining,
  input  logic          fixed,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] steps;
  assign steps = AW'(remaining) - AW'(1);
  assign addr  = fixed ? end_ptr : end_ptr - (steps << SHIFT);
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_eng_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int ITEM_SHIFT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          chan_req,
  input  logic [31:0]   ctl_word,
  input  logic [AW-1:0] src_end,
  input  logic [AW-1:0] dst_end,
  input  logic          src_fixed,
  input  logic          dst_fixed,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          wb_valid,
  output logic [31:0]   wb_word,
  output logic          done
);
  localparam int CW = SIZE_W + 1;

  eng_state_t           state, state_d;
  logic [CTL_W-1:0]     ctl_q;
  logic [AW-1:0]        src_q, dst_q;
  logic                 sfix_q, dfix_q;
  logic                 accept, item_done;
  logic [CW-1:0]        remaining;
  logic                 burst_last;
  logic [AW-1:0]        src_addr, dst_addr;
  logic [MODE_W-1:0]    start_mode, run_mode;
  logic [SIZE_W-1:0]    left_field;

  assign start_mode = ctl_word[MODE_LSB +: MODE_W];
  assign run_mode   = ctl_q[MODE_LSB +: MODE_W];
  assign accept     = (state == ST_IDLE) && start &&
                      ((start_mode == MODE_BASIC) || (start_mode == MODE_AUTO));
  assign item_done  = (state == ST_WR);

  // Next state
  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE: if (accept) state_d = ST_ARB;
      ST_ARB:  if (bus_gnt) state_d = ST_RD;
      ST_RD:   state_d = ST_WR;
      ST_WR: begin
        if (remaining == CW'(1)) state_d = ST_FIN;
        else if (burst_last)     state_d = ST_BND;
        else                     state_d = ST_RD;
      end
      ST_BND:  state_d = ((run_mode == MODE_AUTO) || chan_req) ? ST_ARB : ST_IDLE;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end

  // Channel context captured at start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      sfix_q <= 1'b0;
      dfix_q <= 1'b0;
    end else if (accept) begin
      ctl_q  <= ctl_word;
      src_q  <= src_end;
      dst_q  <= dst_end;
      sfix_q <= src_fixed;
      dfix_q <= dst_fixed;
    end
  end

  dma_item_ctr #(.CW(CW)) u_items (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val ({1'b0, ctl_word[SIZE_LSB +: SIZE_W]} + CW'(1)),
    .dec      (item_done),
    .count    (remaining)
  );

  dma_burst_ctr #(.EW(ARB_W)) u_burst (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept || (state == ST_BND)),
    .step  (item_done),
    .exp_n (ctl_q[ARB_LSB +: ARB_W]),
    .last  (burst_last)
  );

  dma_addr_gen #(.AW(AW), .CW(CW), .SHIFT(ITEM_SHIFT)) u_src_addr (
    .end_ptr (src_q), .remaining (remaining), .fixed (sfix_q), .addr (src_addr)
  );

  dma_addr_gen #(.AW(AW), .CW(CW), .SHIFT(ITEM_SHIFT)) u_dst_addr (
    .end_ptr (dst_q), .remaining (remaining), .fixed (dfix_q), .addr (dst_addr)
  );

  // Outputs
  assign left_field = SIZE_W'(remaining - CW'(1));
  assign bus_req    = (state == ST_ARB) || (state == ST_RD) || (state == ST_WR);
  assign mem_req    = (state == ST_RD) || (state == ST_WR);
  assign mem_we     = (state == ST_WR);
  assign mem_addr   = (state == ST_WR) ? dst_addr : src_addr;
  assign mem_wdata  = mem_rdata;
  assign wb_valid   = (state == ST_BND) || (state == ST_FIN);
  assign done       = (state == ST_FIN);

  always_comb begin
    wb_word = ctl_q;
    if (state == ST_FIN) begin
      wb_word[SIZE_LSB +: SIZE_W] = '0;
      wb_word[MODE_LSB +: MODE_W] = MODE_STOP;
    end else begin
      wb_word[SIZE_LSB +: SIZE_W] = left_field;
    end
  end
endmodule

// File: rtl/dma_chan_engine_chk.sv
module dma_chan_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_req,
  input logic        bus_gnt,
  input logic        mem_req,
  input logic        mem_we,
  input logic        wb_valid,
  input logic [31:0] wb_word,
  input logic        done
);
  a_r1_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |=> (mem_req && mem_we));

  a_r4_burst_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(bus_req && bus_gnt));

  a_r3_release_on_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (!bus_req && !mem_req));

  a_r5_writeback_single: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> !wb_valid);

  a_r7_done_stops_mode: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (wb_valid && wb_word[2:0] == 3'd0 && wb_word[13:4] == 10'd0));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind dma_chan_engine dma_chan_engine_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_req  (bus_req),
  .bus_gnt  (bus_gnt),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .wb_valid (wb_valid),
  .wb_word  (wb_word),
  .done     (done)
);

// File: tb/tb_dma_chan_engine.sv
module tb_dma_chan_engine;
  logic        clk, rst_n, start, chan_req, src_fixed, dst_fixed, bus_gnt;
  logic [31:0] ctl_word, src_end, dst_end;
  logic        bus_req, mem_req, mem_we, wb_valid, done;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, wb_word;

  int compared = 0, mismatched = 0, done_cnt = 0, cyc = 0, gnt_mode = 0;
  logic [31:0] mem [256];

  // reference model state
  int m_phase = 0, m_left = 0, m_inb = 0;
  logic [31:0] m_ctl, m_src, m_dst;
  logic m_sfix, m_dfix;

  dma_chan_engine dut (.*);

  initial begin clk = 0; forever #4 clk = ~clk; end

  // memory with one-cycle read latency
  always @(posedge clk) begin
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[9:2]];
    if (mem_req && mem_we)  mem[mem_addr[9:2]] <= mem_wdata;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mk(input int mode, input int xs, input int arb);
    return {14'h2D6B, 4'(arb), 10'(xs), 1'b1, 3'(mode)};
  endfunction

  // behavioural model and per-cycle comparison
  initial forever begin
    @(posedge clk);
    cyc++;
    if (done) done_cnt++;
    if (!rst_n) m_phase = 0;
    else begin
      case (m_phase)
        0: if (start && (ctl_word[2:0] == 1 || ctl_word[2:0] == 2)) begin
             m_ctl = ctl_word; m_src = src_end; m_dst = dst_end;
             m_sfix = src_fixed; m_dfix = dst_fixed;
             m_left = int'(ctl_word[13:4]) + 1; m_inb = 0; m_phase = 1;
           end
        1: if (bus_gnt) m_phase = 2;
        2: m_phase = 3;
        3: begin
             m_left--; m_inb++;
             if (m_left == 0) m_phase = 5;
             else if (m_inb == (1 << m_ctl[17:14])) begin m_inb = 0; m_phase = 4; end
             else m_phase = 2;
           end
        4: m_phase = (m_ctl[2:0] == 2 || chan_req) ? 1 : 0;
        default: m_phase = 0;
      endcase
    end
    #2;
    if (rst_n) begin
      logic [31:0] ea, ew;
      chk(bus_req == (m_phase >= 1 && m_phase <= 3), "R3/R4 bus_req", 32'(bus_req), 32'(m_phase >= 1 && m_phase <= 3));
      chk(mem_req == (m_phase == 2 || m_phase == 3), "R1 mem_req", 32'(mem_req), 32'(m_phase == 2 || m_phase == 3));
      if (m_phase == 2 || m_phase == 3) begin
        chk(mem_we == (m_phase == 3), "R1 mem_we", 32'(mem_we), 32'(m_phase == 3));
        if (m_phase == 2) ea = m_sfix ? m_src : m_src - 32'((m_left - 1) * 4);
        else              ea = m_dfix ? m_dst : m_dst - 32'((m_left - 1) * 4);
        chk(mem_addr == ea, "R2 mem_addr", mem_addr, ea);
      end
      chk(wb_valid == (m_phase >= 4), "R5 wb_valid", 32'(wb_valid), 32'(m_phase >= 4));
      chk(done == (m_phase == 5), "R7 done", 32'(done), 32'(m_phase == 5));
      if (m_phase == 4) begin
        ew = m_ctl; ew[13:4] = 10'(m_left - 1);
        chk(wb_word == ew, "R5 wb_word", wb_word, ew);
      end
      if (m_phase == 5) begin
        ew = m_ctl; ew[13:4] = 10'd0; ew[2:0] = 3'd0;
        chk(wb_word == ew, "R7 wb_word", wb_word, ew);
      end
    end
  end

  // grant driver
  initial forever begin
    @(negedge clk);
    bus_gnt <= (gnt_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
  end

  initial begin
    #1200000;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  task automatic kick(input logic [31:0] w, input logic [31:0] s, input logic [31:0] d,
                      input bit sf, input bit df);
    @(negedge clk);
    ctl_word = w; src_end = s; dst_end = d; src_fixed = sf; dst_fixed = df; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
    while (m_phase != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int d0;
    logic [31:0] ev;
    for (int i = 0; i < 256; i++) mem[i] = 32'hA500_0000 + i;
    rst_n = 0; start = 0; chan_req = 0; ctl_word = 0; src_end = 0; dst_end = 0;
    src_fixed = 0; dst_fixed = 0; bus_gnt = 1; mem_rdata = 0;
    repeat (3) @(negedge clk);
    chk(!bus_req && !mem_req && !wb_valid && !done, "R10 reset outputs", {bus_req, mem_req, wb_valid, done}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!bus_req && !mem_req && !wb_valid && !done, "R10 after release", {bus_req, mem_req, wb_valid, done}, 0);

    // R1 auto mode, 8 items, bursts of 4
    kick(mk(2, 7, 2), 32'h01C, 32'h21C, 0, 0);
    settle();
    for (int j = 0; j < 8; j++) begin
      ev = 32'hA500_0000 + j;
      chk(mem[8'h80 + j] == ev, "R1 auto data", mem[8'h80 + j], ev);
    end
    chk(done_cnt == 1, "R7 one done", done_cnt, 1);

    // R4 grant toggling, 16 items bursts of 8, plus R9 start while busy
    gnt_mode = 1;
    kick(mk(2, 15, 3), 32'h0BC, 32'h2BC, 0, 0);
    repeat (6) @(negedge clk);
    kick(mk(2, 3, 0), 32'h0FC, 32'h3FC, 0, 0);
    settle();
    gnt_mode = 0;
    for (int j = 0; j < 16; j++) begin
      ev = 32'hA500_0020 + j;
      chk(mem[8'hA0 + j] == ev, "R4 gated data", mem[8'hA0 + j], ev);
    end
    chk(mem[8'hFF] == 32'hA500_00FF, "R9 busy start ignored", mem[8'hFF], 32'hA500_00FF);
    chk(done_cnt == 2, "R9 single done", done_cnt, 2);

    // R2 fixed destination
    kick(mk(2, 3, 1), 32'h10C, 32'h300, 0, 1);
    settle();
    chk(mem[8'hC0] == 32'hA500_0043, "R2 fixed dst last item", mem[8'hC0], 32'hA500_0043);

    // R2 fixed source, no boundary with large exponent
    kick(mk(2, 3, 15), 32'h120, 32'h33C, 1, 0);
    settle();
    for (int j = 0; j < 4; j++)
      chk(mem[8'hCC + j] == 32'hA500_0048, "R2 fixed src", mem[8'hCC + j], 32'hA500_0048);

    // R6 basic mode parks, then resumes from written-back word
    d0 = done_cnt;
    chan_req = 0;
    kick(mk(1, 5, 1), 32'h054, 32'h254, 0, 0);
    settle();
    chk(done_cnt == d0, "R6 parked no done", done_cnt, d0);
    chk(mem[8'h92] == 32'hA500_0092, "R6 parked no extra item", mem[8'h92], 32'hA500_0092);
    chan_req = 1;
    kick(mk(1, 3, 1), 32'h054, 32'h254, 0, 0);
    settle();
    chan_req = 0;
    for (int j = 0; j < 6; j++) begin
      ev = 32'hA500_0010 + j;
      chk(mem[8'h90 + j] == ev, "R6 resumed data", mem[8'h90 + j], ev);
    end
    chk(done_cnt == d0 + 1, "R6 resumed done", done_cnt, d0 + 1);

    // R8 stop and unsupported modes ignored
    d0 = done_cnt;
    kick(mk(0, 3, 0), 32'h1FC, 32'h3F0, 0, 0);
    settle();
    kick(mk(5, 3, 0), 32'h1FC, 32'h3F0, 0, 0);
    settle();
    chk(done_cnt == d0, "R8 no done", done_cnt, d0);
    chk(mem[8'hFC] == 32'hA500_00FC, "R8 no write", mem[8'hFC], 32'hA500_00FC);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule